// File: doc/BRIEF.md
# Trigger Input Conditioning and Delay

This block takes three asynchronous external trigger lines and brings each into the clock domain through a two-stage synchronizer. Each line then passes a per-line enable, and the enabled lines are ORed into one combined trigger. A rising edge of the combined trigger starts a pulse of fixed length. That pulse can be routed through a programmable delay, chosen separately for each output, before it drives three gated external trigger outputs and one ungated back-end trigger.

Software observes the trigger at four points of the chain, called taps: the synchronized input, the input after its enable, the combined trigger before stretching, and the back-end trigger as driven. Each tap has a live status bit and a sticky rising-edge capture bit. A counter records how many back-end trigger pulses have been sent. All control uses a single-cycle write, word-wide register bus whose read data is combinational from the address.

Top module: `trg_cond_top`

## Requirements
- R1: After reset every register reads zero. Register offsets are 0x04 input enable (bits 2:0), 0x08 status, 0x0C capture, 0x10 output enable (bits 2:0), 0x14 pulse counter and 0x18 delay control (value in bits 15:0, select in bits 19:16). Bits without storage and unused offsets read zero.
- R2: Input n is a rising input to the chain only when input-enable bit n is 1. An input that is enabled and rises, with the change made between clock edges, makes the undelayed trigger high from the third rising clock edge after the change. A disabled input produces no trigger.
- R3: Status bits show live levels. Bits 2:0 are the synchronized inputs, bits 10:8 the inputs after enable, bit 16 the combined trigger before stretching, and bit 17 the back-end trigger.
- R4: Capture register bits share the status layout. A bit sets on a low-to-high change of its tap and holds until a write to 0x0C carries 0 in that position. A write leaves the bits written as 1 untouched.
- R5: When a rising edge of a tap meets a capture-clearing write in the same cycle, the bit ends set.
- R6: Output-enable bit n gates external output n. The back-end trigger is never gated.
- R7: The 32-bit counter at 0x14 increments on each rising edge of the back-end trigger. Any write to 0x14 clears it.
- R8: Each rising edge of the combined trigger makes a pulse exactly 4 cycles long, however long the input stays high.
- R9: With delay value D ≥ 1, a path whose select bit is set (bit 16+n for external output n, bit 19 for the back-end trigger) starts its pulse D cycles after the undelayed pulse, with the same length. With D = 0 the delayed path equals the undelayed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one delay step per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_in_i | input | 3 | Asynchronous external trigger lines |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| trig_out_o | output | 3 | Gated external trigger outputs |
| trig_be_o | output | 1 | Ungated back-end trigger |

## Verification
The assertions assume that the trigger lines are sampled only through the synchronizer. They also assume that a capture or counter write lasts exactly one cycle, so stickiness and single-step counting can be checked between writes. The stimulus changes trigger lines and bus signals only at falling clock edges. Every pulse runs out before the next line change, so no delayed pulse is still pending when the next trigger arrives. The delay sweep stays at small values, which keeps each pulse window short enough to capture cycle by cycle.

// File: rtl/trg_cond_pkg.sv
package trg_cond_pkg;
  localparam logic [7:0] ADR_INEN  = 8'h04;
  localparam logic [7:0] ADR_STAT  = 8'h08;
  localparam logic [7:0] ADR_CATCH = 8'h0C;
  localparam logic [7:0] ADR_OEN   = 8'h10;
  localparam logic [7:0] ADR_CNT   = 8'h14;
  localparam logic [7:0] ADR_DLY   = 8'h18;

  localparam int unsigned TAP_RAW_LSB = 0;
  localparam int unsigned TAP_EN_LSB  = 8;
  localparam int unsigned TAP_ALL_BIT = 16;
  localparam int unsigned TAP_BE_BIT  = 17;
  localparam int unsigned DSEL_LSB    = 16;
endpackage

// File: rtl/trg_sync_2ff.sv
module trg_sync_2ff #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/trg_pulse_stretch.sv
module trg_pulse_stretch #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic          trig_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise;

  assign rise = trig_i & ~trig_q;

  always_comb begin
    cnt_d = cnt_q;
    if (rise)             cnt_d = CW'(LEN);
    else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      trig_q <= trig_i;
      cnt_q  <= cnt_d;
    end
  end

  assign pulse_o = (cnt_q != '0);

  AST_STRETCH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !trig_q) |=> pulse_o); // R8
  AST_STRETCH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(trig_i)); // R8
endmodule

// File: rtl/trg_pulse_delay.sv
module trg_pulse_delay #(
  parameter int unsigned DLY_W = 16,
  parameter int unsigned LEN   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             pulse_o
);
  localparam int unsigned PW = $clog2(LEN);

  logic             trig_q;
  logic [DLY_W-1:0] wait_q, wait_d;
  logic [PW-1:0]    tail_q, tail_d;
  logic             idle, fire, bypass;

  assign idle   = (wait_q == '0) && (tail_q == '0);
  assign fire   = (wait_q == DLY_W'(1));
  assign bypass = (dly_i == '0);

  always_comb begin
    wait_d = wait_q;
    tail_d = tail_q;
    if (wait_q != '0)      wait_d = wait_q - DLY_W'(1);
    else if (idle && !bypass && trig_i && !trig_q) wait_d = dly_i;
    if (fire)              tail_d = PW'(LEN - 1);
    else if (tail_q != '0) tail_d = tail_q - PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      wait_q <= '0;
      tail_q <= '0;
    end else begin
      trig_q <= trig_i;
      wait_q <= wait_d;
      tail_q <= tail_d;
    end
  end

  assign pulse_o = bypass ? trig_i : (fire || (tail_q != '0));

  AST_DLY_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !trig_q && idle && dly_i != '0) |-> !pulse_o); // R9
endmodule

// File: rtl/trg_cond_top.sv
module trg_cond_top #(
  parameter int unsigned N_TRIG  = 3,
  parameter int unsigned STRETCH = 4,
  parameter int unsigned DLY_W   = 16,
  parameter int unsigned CNT_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_in_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [N_TRIG-1:0] trig_out_o,
  output logic              trig_be_o
);
  import trg_cond_pkg::*;

  localparam int unsigned SEL_W = N_TRIG + 1;
  localparam logic [31:0] LANES = 32'((64'd1 << N_TRIG) - 64'd1);
  localparam logic [31:0] TAP_MASK = (LANES << TAP_RAW_LSB) | (LANES << TAP_EN_LSB)
                                   | (32'd1 << TAP_ALL_BIT) | (32'd1 << TAP_BE_BIT);

  // reset release synchronizer
  logic [1:0] rst_sh_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sh_q <= 2'b00;
    else         rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_n = rst_sh_q[1];

  // register file state
  logic [N_TRIG-1:0] inen_q, inen_d, oen_q, oen_d;
  logic [DLY_W-1:0]  dval_q, dval_d;
  logic [SEL_W-1:0]  dsel_q, dsel_d;
  logic [31:0]       catch_q, catch_d, tap_q, tap_w;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic wr_inen, wr_oen, wr_catch, wr_cnt, wr_dly;
  assign wr_inen  = bus_we_i && (bus_addr_i == ADR_INEN);
  assign wr_oen   = bus_we_i && (bus_addr_i == ADR_OEN);
  assign wr_catch = bus_we_i && (bus_addr_i == ADR_CATCH);
  assign wr_cnt   = bus_we_i && (bus_addr_i == ADR_CNT);
  assign wr_dly   = bus_we_i && (bus_addr_i == ADR_DLY);

  // trigger chain
  logic [N_TRIG-1:0] raw, gated;
  logic              combined, stretched, delayed;

  trg_sync_2ff #(.W(N_TRIG)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_n), .d_i(trig_in_i), .q_o(raw)
  );

  assign gated    = raw & inen_q;
  assign combined = |gated;

  trg_pulse_stretch #(.LEN(STRETCH)) u_stretch (
    .clk_i(clk_i), .rst_ni(rst_n), .trig_i(combined), .pulse_o(stretched)
  );

  trg_pulse_delay #(.DLY_W(DLY_W), .LEN(STRETCH)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_n), .trig_i(stretched), .dly_i(dval_q), .pulse_o(delayed)
  );

  for (genvar g = 0; g < N_TRIG; g++) begin : g_out
    assign trig_out_o[g] = oen_q[g] & (dsel_q[g] ? delayed : stretched);
  end
  assign trig_be_o = dsel_q[N_TRIG] ? delayed : stretched;

  // observation taps
  always_comb begin
    tap_w = '0;
    tap_w[TAP_RAW_LSB +: N_TRIG] = raw;
    tap_w[TAP_EN_LSB  +: N_TRIG] = gated;
    tap_w[TAP_ALL_BIT]           = combined;
    tap_w[TAP_BE_BIT]            = trig_be_o;
  end

  // next state
  always_comb begin
    inen_d  = wr_inen ? bus_wdata_i[N_TRIG-1:0] : inen_q;
    oen_d   = wr_oen  ? bus_wdata_i[N_TRIG-1:0] : oen_q;
    dval_d  = wr_dly  ? bus_wdata_i[DLY_W-1:0] : dval_q;
    dsel_d  = wr_dly  ? bus_wdata_i[DSEL_LSB +: SEL_W] : dsel_q;
    catch_d = ((catch_q & (wr_catch ? bus_wdata_i : 32'hFFFF_FFFF))
               | (tap_w & ~tap_q)) & TAP_MASK;
    cnt_d   = wr_cnt ? '0 : cnt_q + CNT_W'(trig_be_o & ~tap_q[TAP_BE_BIT]);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      inen_q  <= '0;
      oen_q   <= '0;
      dval_q  <= '0;
      dsel_q  <= '0;
      catch_q <= '0;
      tap_q   <= '0;
      cnt_q   <= '0;
    end else begin
      inen_q  <= inen_d;
      oen_q   <= oen_d;
      dval_q  <= dval_d;
      dsel_q  <= dsel_d;
      catch_q <= catch_d;
      tap_q   <= tap_w & TAP_MASK;
      cnt_q   <= cnt_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADR_INEN:  bus_rdata_o[N_TRIG-1:0] = inen_q;
      ADR_STAT:  bus_rdata_o = tap_w;
      ADR_CATCH: bus_rdata_o = catch_q;
      ADR_OEN:   bus_rdata_o[N_TRIG-1:0] = oen_q;
      ADR_CNT:   bus_rdata_o[CNT_W-1:0] = cnt_q;
      ADR_DLY: begin
        bus_rdata_o[DLY_W-1:0]         = dval_q;
        bus_rdata_o[DSEL_LSB +: SEL_W] = dsel_q;
      end
      default:   bus_rdata_o = '0;
    endcase
  end

  AST_CATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_catch |=> ((catch_q & $past(catch_q)) == $past(catch_q))); // R4
  AST_CNT_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1))); // R7
  AST_BE_UNGATED: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(stretched) && !dsel_q[N_TRIG]) |-> trig_be_o); // R6
endmodule

// File: tb/test_trg_cond_top.sv
`timescale 1ns/1ps
module test_trg_cond_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  trig_in_i;
  logic        bus_we_i;
  logic [7:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic [2:0]  trig_out_o;
  logic        trig_be_o;

  trg_cond_top i_trg_cond_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_in_i(trig_in_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .trig_out_o(trig_out_o), .trig_be_o(trig_be_o)
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [32:0] be_h;
  logic [32:0] oh [3];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #0.5;
    d = bus_rdata_o;
  endtask

  task automatic fire(input int idx, input int hold);
    trig_in_i[idx] = 1'b1;
    for (int c = 1; c <= 32; c++) begin
      @(posedge clk_i); @(negedge clk_i);
      be_h[c] = trig_be_o;
      for (int j = 0; j < 3; j++) oh[j][c] = trig_out_o[j];
      if (c == hold) trig_in_i[idx] = 1'b0;
    end
    be_h[0] = 1'b0;
    for (int j = 0; j < 3; j++) oh[j][0] = 1'b0;
  endtask

  function automatic logic [32:0] pulse_vec(input int start);
    logic [32:0] v = '0;
    if (start > 0)
      for (int c = start; c < start + 4; c++) v[c] = 1'b1;
    return v;
  endfunction

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int dl [6] = '{0, 1, 2, 3, 7, 12};
    rst_ni = 1'b0; trig_in_i = '0; bus_we_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R1: reset values
    foreach (dl[k]) begin end
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), r);
      chk(r == 32'h0, "R1 reset", r, 0);
    end
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, r); chk(r == 32'h7, "R1 inen width", r, 32'h7);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, r); chk(r == 32'h000F_FFFF, "R1 dly width", r, 32'h000F_FFFF);
    wr(8'h10, 32'hFFFF_FFF8); rd(8'h10, r); chk(r == 32'h0, "R1 oen width", r, 0);
    rd(8'h20, r); chk(r == 32'h0, "R1 unused offset", r, 0);
    wr(8'h18, 32'h0);

    // R2/R8: enable sweep, undelayed start at third edge, 4 cycles long
    wr(8'h10, 32'h7);
    for (int m = 0; m < 8; m++) begin
      wr(8'h04, 32'(m));
      for (int i = 0; i < 3; i++) begin
        fire(i, 2);
        chk(be_h == pulse_vec(m[i] ? 3 : 0), "R2 enable sweep be", 64'(be_h), 64'(pulse_vec(m[i] ? 3 : 0)));
        chk(oh[i] == pulse_vec(m[i] ? 3 : 0), "R2 enable sweep out", 64'(oh[i]), 64'(pulse_vec(m[i] ? 3 : 0)));
      end
    end

    // R8: long input still gives a 4-cycle pulse
    wr(8'h04, 32'h7);
    fire(1, 12);
    chk(be_h == pulse_vec(3), "R8 long hold", 64'(be_h), 64'(pulse_vec(3)));

    // R6: output enable sweep; back-end never gated
    for (int m = 0; m < 8; m++) begin
      wr(8'h10, 32'(m));
      fire(0, 2);
      chk(be_h == pulse_vec(3), "R6 be ungated", 64'(be_h), 64'(pulse_vec(3)));
      for (int j = 0; j < 3; j++)
        chk(oh[j] == pulse_vec(m[j] ? 3 : 0), "R6 out gate", 64'(oh[j]), 64'(pulse_vec(m[j] ? 3 : 0)));
    end

    // R9: delay sweep with every path selected
    wr(8'h10, 32'h7);
    for (int k = 0; k < 6; k++) begin
      wr(8'h18, 32'h000F_0000 | 32'(dl[k]));
      fire(2, 2);
      chk(be_h == pulse_vec(3 + dl[k]), "R9 delay be", 64'(be_h), 64'(pulse_vec(3 + dl[k])));
      chk(oh[0] == pulse_vec(3 + dl[k]), "R9 delay out0", 64'(oh[0]), 64'(pulse_vec(3 + dl[k])));
    end
    // R9: select only output 0
    wr(8'h18, 32'h0001_0005);
    fire(0, 2);
    chk(oh[0] == pulse_vec(8), "R9 sel out0 delayed", 64'(oh[0]), 64'(pulse_vec(8)));
    chk(oh[1] == pulse_vec(3), "R9 sel out1 direct", 64'(oh[1]), 64'(pulse_vec(3)));
    chk(be_h == pulse_vec(3), "R9 sel be direct", 64'(be_h), 64'(pulse_vec(3)));
    wr(8'h18, 32'h0);

    // R3: live status at the second sample after the change
    wr(8'h04, 32'h1);
    trig_in_i[0] = 1'b1;
    repeat (2) begin @(posedge clk_i); @(negedge clk_i); end
    rd(8'h08, r); chk(r == 32'h0001_0101, "R3 status pre-stretch", r, 32'h0001_0101);
    @(posedge clk_i); @(negedge clk_i);
    rd(8'h08, r); chk(r == 32'h0003_0101, "R3 status final", r, 32'h0003_0101);
    trig_in_i[0] = 1'b0;
    repeat (10) @(negedge clk_i);
    rd(8'h08, r); chk(r == 32'h0, "R3 status idle", r, 0);

    // R4: capture behaviour
    wr(8'h0C, 32'h0);
    rd(8'h0C, r); chk(r == 32'h0, "R4 cleared", r, 0);
    fire(1, 2);
    rd(8'h0C, r); chk(r == 32'h0000_0002, "R4 disabled input", r, 32'h2);
    fire(0, 2);
    rd(8'h0C, r); chk(r == 32'h0003_0103, "R4 enabled input", r, 32'h0003_0103);
    wr(8'h0C, 32'hFFFF_FFFE);
    rd(8'h0C, r); chk(r == 32'h0003_0102, "R4 partial clear", r, 32'h0003_0102);

    // R5: edge meets clearing write
    wr(8'h0C, 32'h0);
    trig_in_i[2] = 1'b1;
    repeat (2) begin @(posedge clk_i); @(negedge clk_i); end
    wr(8'h0C, 32'h0);
    trig_in_i[2] = 1'b0;
    repeat (10) @(negedge clk_i);
    rd(8'h0C, r); chk(r == 32'h4, "R5 edge wins", r, 32'h4);

    // R7: counter
    wr(8'h14, 32'h0);
    for (int n = 0; n < 5; n++) fire(0, 2);
    rd(8'h14, r); chk(r == 32'd5, "R7 count", r, 5);
    wr(8'h14, 32'h1234);
    rd(8'h14, r); chk(r == 32'd0, "R7 clear", r, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule